// File: doc/BRIEF.md
# Accumulator Teaching Processor Core

This block is a small processor built around one 8-bit accumulator. It steps through a fetch, decode and execute loop against a byte-wide external memory. Every access goes through an address register, a data register, a read/write level and a single-cycle access strobe. The instruction set has eleven one-byte opcodes whose values are decimal numbers stored as binary bytes. An odd opcode is followed by two operand bytes, high byte first, and those bytes form a decimal address: high times one hundred plus low.

The core keeps three status bits: zero, negative and halted. Only the arithmetic instructions and the clear instruction change the zero and negative bits. The display instruction reads one byte from memory and presents it on an output port together with a one-cycle valid pulse. After halting, or after fetching an opcode it does not recognise, the core issues no further memory accesses. It resumes only after an active-low reset, which restarts execution at address 0.

Top module: `acc_core`

## Requirements
- R1: While reset is held and right after it, A reads 0, the zero, negative, halted and illegal outputs read 0, and the first memory access is a read at address 0.
- R2: Odd opcodes read two more bytes at PC+1 and PC+2; even opcodes read none. The next opcode is then read at the address that follows. These reads come in that order, before any data access made by the instruction.
- R3: Operand bytes hi and lo (each 0..99) select address hi*100+lo. For example, bytes 12 and 34 select address 1234.
- R4: A read asserts mem_req for exactly one cycle with mem_rw=1, and the byte on mem_rdata in the following cycle is taken. A write asserts mem_req for one cycle with mem_rw=0, with mem_wdata equal to A.
- R5: CLA (opcode 08) sets A to 0, Z to 1 and N to 0.
- R6: INC (10), ADD (99) and SUB (61) compute A+1, A+mem and A-mem modulo 256. They then set Z when the result is 0 and set N to bit 7 of the result.
- R7: LDA (91), STA (39), JMP (15), JZ (17), JN (19) and DSP (01) leave Z and N unchanged. LDA loads A from memory and STA stores A to memory.
- R8: JMP always loads PC with the operand address. JZ does so only when Z=1 and JN only when N=1; otherwise execution continues with the next instruction.
- R9: DSP presents the byte at its operand address on dsp_data, with dsp_valid high for exactly one cycle.
- R10: HLT (64) sets halted. From the cycle halted rises, halted stays 1 and mem_req stays 0 until reset.
- R11: Any opcode byte outside the eleven listed values sets both illegal and halted. No operand bytes are read and no further accesses follow.
- R12: The repeated-subtraction division program with X=25 and Y=7 displays 3 and then 4. It also stores 3 and 4 at addresses 44 and 45, then halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 14 | Memory address register contents |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_req | output | 1 | Access strobe, one cycle per access |
| mem_wdata | output | 8 | Memory data register, written on a write access |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read strobe |
| dsp_data | output | 8 | Byte shown by the display instruction |
| dsp_valid | output | 1 | One-cycle pulse when dsp_data is new |
| acc_out | output | 8 | Accumulator |
| zero_flag | output | 1 | Zero status bit |
| neg_flag | output | 1 | Negative status bit |
| halted | output | 1 | Halt status bit |
| illegal | output | 1 | Unrecognised opcode was fetched |

## Verification
The assertions assume that memory returns read data exactly one cycle after the strobe and never holds off an access. They also assume that every operand byte stored in memory lies between 0 and 99, so every computed address stays inside 0..9999. The bench's memory model answers every strobe with a registered read one cycle later, which matches that timing. Each program it loads uses only decimal operand bytes of 99 or less, and the bench never drives mem_rdata on its own.

// File: rtl/acc_pkg.sv
// Package: opcode values, instruction classes and sequencer states for the
// accumulator core. Assumes byte-wide opcodes holding decimal values.
package acc_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_LDA = 8'd91;
    localparam logic [OP_W-1:0] OPC_STA = 8'd39;
    localparam logic [OP_W-1:0] OPC_CLA = 8'd8;
    localparam logic [OP_W-1:0] OPC_INC = 8'd10;
    localparam logic [OP_W-1:0] OPC_ADD = 8'd99;
    localparam logic [OP_W-1:0] OPC_SUB = 8'd61;
    localparam logic [OP_W-1:0] OPC_JMP = 8'd15;
    localparam logic [OP_W-1:0] OPC_JZ  = 8'd17;
    localparam logic [OP_W-1:0] OPC_JN  = 8'd19;
    localparam logic [OP_W-1:0] OPC_DSP = 8'd1;
    localparam logic [OP_W-1:0] OPC_HLT = 8'd64;

    typedef enum logic [3:0] {
        K_LDA, K_STA, K_CLA, K_INC, K_ADD, K_SUB,
        K_JMP, K_JZ, K_JN, K_DSP, K_HLT, K_BAD
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_SETUP,   // put PC into MAR, advance PC
        ST_RDREQ,   // read strobe cycle
        ST_RDCAP,   // read byte is on the bus
        ST_EXEC,    // act on the decoded instruction
        ST_FINISH,  // complete an instruction that needed a data byte
        ST_WRREQ,   // write strobe cycle
        ST_HALT     // stopped until reset
    } seq_state_t;

    typedef enum logic [1:0] {
        RS_OPCODE,  // byte being read is an opcode
        RS_HIGH,    // byte being read is the operand high part
        RS_LOW,     // byte being read is the operand low part
        RS_DATA     // byte being read is instruction data
    } read_step_t;

endpackage

// File: rtl/acc_decode.sv
// Opcode decoder: maps an opcode byte to its instruction class.
// Assumes the operand presence follows opcode parity; unknown bytes map to K_BAD.
module acc_decode
    import acc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_kind_t        kind,
    output logic            has_operand,
    output logic            bad
);

    // classify the byte against the fixed opcode list
    always_comb begin
        case (opcode)
            OPC_LDA: kind = K_LDA;
            OPC_STA: kind = K_STA;
            OPC_CLA: kind = K_CLA;
            OPC_INC: kind = K_INC;
            OPC_ADD: kind = K_ADD;
            OPC_SUB: kind = K_SUB;
            OPC_JMP: kind = K_JMP;
            OPC_JZ:  kind = K_JZ;
            OPC_JN:  kind = K_JN;
            OPC_DSP: kind = K_DSP;
            OPC_HLT: kind = K_HLT;
            default: kind = K_BAD;
        endcase
    end

    assign has_operand = opcode[0];
    assign bad         = (kind == K_BAD);

endmodule

// File: rtl/acc_alu.sv
// Accumulator ALU: computes the next accumulator value and the zero and
// negative bits. Assumes two's complement wrap at DATA_W bits.
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_kind_t          kind,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              res_zero,
    output logic              res_neg,
    output logic              writes_acc,
    output logic              writes_flags
);

    // select the arithmetic result for the instruction class
    always_comb begin
        case (kind)
            K_CLA:   result = '0;
            K_INC:   result = acc + DATA_W'(1);
            K_ADD:   result = acc + operand;
            K_SUB:   result = acc - operand;
            K_LDA:   result = operand;
            default: result = acc;
        endcase
    end

    // mark which instructions update the accumulator and the flags
    always_comb begin
        writes_acc   = (kind == K_CLA) || (kind == K_INC) || (kind == K_ADD)
                    || (kind == K_SUB) || (kind == K_LDA);
        writes_flags = (kind == K_CLA) || (kind == K_INC) || (kind == K_ADD)
                    || (kind == K_SUB);
    end

    assign res_zero = (result == '0);
    assign res_neg  = result[DATA_W-1];

endmodule

// File: rtl/acc_eff_addr.sv
// Effective address former: joins the operand high and low bytes as
// high*RADIX+low. Assumes both bytes are below RADIX; the result is truncated
// to ADDR_W bits.
module acc_eff_addr #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14,
    parameter int RADIX  = 100
) (
    input  logic [DATA_W-1:0] hi_byte,
    input  logic [DATA_W-1:0] lo_byte,
    output logic [ADDR_W-1:0] addr
);

    localparam int WIDE_W = ADDR_W + DATA_W;

    generate
        if (RADIX == (1 << DATA_W)) begin : g_concat
            // binary radix: the bytes simply concatenate
            logic [2*DATA_W-1:0] joined;
            assign joined = {hi_byte, lo_byte};
            assign addr   = ADDR_W'(joined);
        end else begin : g_scaled
            // decimal or other radix: scale the high byte and add the low byte
            logic [WIDE_W-1:0] wide;
            assign wide = (WIDE_W'(hi_byte) * WIDE_W'(RADIX)) + WIDE_W'(lo_byte);
            assign addr = wide[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/acc_core.sv
// Accumulator processor core: sequences fetch, operand fetch and execution
// over a byte memory whose read data arrives one cycle after the strobe.
// Assumes memory never stalls; halts on HLT or on an unknown opcode.
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14,
    parameter int RADIX  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rw,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dsp_data,
    output logic              dsp_valid,
    output logic [DATA_W-1:0] acc_out,
    output logic              zero_flag,
    output logic              neg_flag,
    output logic              halted,
    output logic              illegal
);

    seq_state_t        state_q;
    read_step_t        step_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [OP_W-1:0]   opcode_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] acc_q;
    logic              z_q;
    logic              n_q;
    logic              h_q;
    logic              bad_q;
    logic              rw_q;
    logic [DATA_W-1:0] dsp_q;
    logic              dsp_v_q;

    logic              fresh_opcode;
    logic [OP_W-1:0]   dec_in;
    op_kind_t          kind;
    logic              dec_opnd;
    logic              dec_bad;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] alu_res;
    logic              alu_z;
    logic              alu_n;
    logic              alu_wa;
    logic              alu_wf;
    logic              take_branch;

    // decode the byte on the bus while it is captured, else the held opcode
    assign fresh_opcode = (state_q == ST_RDCAP) && (step_q == RS_OPCODE);
    assign dec_in       = fresh_opcode ? OP_W'(mem_rdata) : opcode_q;

    acc_decode i_decode (
        .opcode      (dec_in),
        .kind        (kind),
        .has_operand (dec_opnd),
        .bad         (dec_bad)
    );

    acc_eff_addr #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .RADIX  (RADIX)
    ) i_eff_addr (
        .hi_byte (hi_q),
        .lo_byte (lo_q),
        .addr    (eff_addr)
    );

    acc_alu #(
        .DATA_W (DATA_W)
    ) i_alu (
        .kind         (kind),
        .acc          (acc_q),
        .operand      (mdr_q),
        .result       (alu_res),
        .res_zero     (alu_z),
        .res_neg      (alu_n),
        .writes_acc   (alu_wa),
        .writes_flags (alu_wf)
    );

    // branch decision from the current flags
    always_comb begin
        case (kind)
            K_JMP:   take_branch = 1'b1;
            K_JZ:    take_branch = z_q;
            K_JN:    take_branch = n_q;
            default: take_branch = 1'b0;
        endcase
    end

    // control sequencer and register set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_SETUP;
            step_q   <= RS_OPCODE;
            pc_q     <= '0;
            mar_q    <= '0;
            mdr_q    <= '0;
            opcode_q <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            acc_q    <= '0;
            z_q      <= 1'b0;
            n_q      <= 1'b0;
            h_q      <= 1'b0;
            bad_q    <= 1'b0;
            rw_q     <= 1'b1;
        end else begin
            case (state_q)
                ST_SETUP: begin
                    mar_q   <= pc_q;
                    pc_q    <= pc_q + ADDR_W'(1);
                    rw_q    <= 1'b1;
                    state_q <= ST_RDREQ;
                end
                ST_RDREQ: begin
                    state_q <= ST_RDCAP;
                end
                ST_RDCAP: begin
                    mdr_q <= mem_rdata;
                    case (step_q)
                        RS_OPCODE: begin
                            opcode_q <= OP_W'(mem_rdata);
                            if (dec_bad) begin
                                bad_q   <= 1'b1;
                                h_q     <= 1'b1;
                                state_q <= ST_HALT;
                            end else if (dec_opnd) begin
                                step_q  <= RS_HIGH;
                                state_q <= ST_SETUP;
                            end else begin
                                state_q <= ST_EXEC;
                            end
                        end
                        RS_HIGH: begin
                            hi_q    <= mem_rdata;
                            step_q  <= RS_LOW;
                            state_q <= ST_SETUP;
                        end
                        RS_LOW: begin
                            lo_q    <= mem_rdata;
                            state_q <= ST_EXEC;
                        end
                        default: begin
                            state_q <= ST_FINISH;
                        end
                    endcase
                end
                ST_EXEC: begin
                    case (kind)
                        K_CLA, K_INC: begin
                            acc_q   <= alu_res;
                            z_q     <= alu_z;
                            n_q     <= alu_n;
                            step_q  <= RS_OPCODE;
                            state_q <= ST_SETUP;
                        end
                        K_LDA, K_ADD, K_SUB, K_DSP: begin
                            mar_q   <= eff_addr;
                            rw_q    <= 1'b1;
                            step_q  <= RS_DATA;
                            state_q <= ST_RDREQ;
                        end
                        K_STA: begin
                            mar_q   <= eff_addr;
                            mdr_q   <= acc_q;
                            rw_q    <= 1'b0;
                            state_q <= ST_WRREQ;
                        end
                        K_JMP, K_JZ, K_JN: begin
                            if (take_branch) begin
                                pc_q <= eff_addr;
                            end
                            step_q  <= RS_OPCODE;
                            state_q <= ST_SETUP;
                        end
                        default: begin
                            h_q     <= 1'b1;
                            state_q <= ST_HALT;
                        end
                    endcase
                end
                ST_FINISH: begin
                    if (alu_wa) begin
                        acc_q <= alu_res;
                    end
                    if (alu_wf) begin
                        z_q <= alu_z;
                        n_q <= alu_n;
                    end
                    step_q  <= RS_OPCODE;
                    state_q <= ST_SETUP;
                end
                ST_WRREQ: begin
                    step_q  <= RS_OPCODE;
                    state_q <= ST_SETUP;
                end
                default: begin
                    state_q <= ST_HALT;
                end
            endcase
        end
    end

    // display port: one-cycle pulse when a display instruction completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_q   <= '0;
            dsp_v_q <= 1'b0;
        end else begin
            dsp_v_q <= (state_q == ST_FINISH) && (kind == K_DSP);
            if ((state_q == ST_FINISH) && (kind == K_DSP)) begin
                dsp_q <= mdr_q;
            end
        end
    end

    assign mem_addr  = mar_q;
    assign mem_rw    = rw_q;
    assign mem_req   = (state_q == ST_RDREQ) || (state_q == ST_WRREQ);
    assign mem_wdata = mdr_q;
    assign dsp_data  = dsp_q;
    assign dsp_valid = dsp_v_q;
    assign acc_out   = acc_q;
    assign zero_flag = z_q;
    assign neg_flag  = n_q;
    assign halted    = h_q;
    assign illegal   = bad_q;

endmodule

// File: rtl/acc_core_chk.sv
// Checker for the accumulator core: port-level timing and status rules.
// Assumes memory answers every strobe without stalling.
module acc_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_rw,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] acc_out,
    input logic              zero_flag,
    input logic              neg_flag,
    input logic              halted,
    input logic              illegal,
    input logic              dsp_valid
);

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_write_is_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rw) |-> (mem_wdata == acc_out));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_flag && neg_flag));

    assert_dsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |=> !dsp_valid);

    assert_no_req_after_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_illegal_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

endmodule

bind acc_core acc_core_chk #(
    .DATA_W (DATA_W)
) i_acc_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_rw    (mem_rw),
    .mem_wdata (mem_wdata),
    .acc_out   (acc_out),
    .zero_flag (zero_flag),
    .neg_flag  (neg_flag),
    .halted    (halted),
    .illegal   (illegal),
    .dsp_valid (dsp_valid)
);

// File: tb/test_acc_core.sv
// Directed bench for acc_core: loads small programs into a registered RAM
// model, runs to halt and checks ports, memory writes and display output.
module test_acc_core;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_DEPTH  = 2048;
    localparam int LOG_N      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] mem_addr;
    logic        mem_rw;
    logic        mem_req;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'd0;
    logic [7:0]  dsp_data;
    logic        dsp_valid;
    logic [7:0]  acc_out;
    logic        zero_flag;
    logic        neg_flag;
    logic        halted;
    logic        illegal;

    logic [7:0]  mem [0:MEM_DEPTH-1];
    int          rd_log [0:LOG_N-1];
    int          wr_addr_log [0:LOG_N-1];
    int          wr_data_log [0:LOG_N-1];
    int          dsp_log [0:LOG_N-1];
    int          rd_n, wr_n, dsp_n, late_req;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core i_acc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rw    (mem_rw),
        .mem_req   (mem_req),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .dsp_data  (dsp_data),
        .dsp_valid (dsp_valid),
        .acc_out   (acc_out),
        .zero_flag (zero_flag),
        .neg_flag  (neg_flag),
        .halted    (halted),
        .illegal   (illegal)
    );

    // synchronous RAM model: write on strobe, read data one cycle later
    always @(posedge clk) begin
        if (mem_req && !mem_rw) mem[mem_addr % MEM_DEPTH] <= mem_wdata;
        if (mem_req && mem_rw)  mem_rdata <= mem[mem_addr % MEM_DEPTH];
    end

    // bus and display recorder, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && halted) late_req++;
            if (mem_req && mem_rw && rd_n < LOG_N) begin
                rd_log[rd_n] = int'(mem_addr);
                rd_n++;
            end
            if (mem_req && !mem_rw && wr_n < LOG_N) begin
                wr_addr_log[wr_n] = int'(mem_addr);
                wr_data_log[wr_n] = int'(mem_wdata);
                wr_n++;
            end
            if (dsp_valid && dsp_n < LOG_N) begin
                dsp_log[dsp_n] = int'(dsp_data);
                dsp_n++;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_DEPTH; i++) mem[i] = 8'd0;
    endtask

    task automatic put(input int a, input int v);
        mem[a] = 8'(v);
    endtask

    // reset, clear the logs, release and run until halted
    task automatic run_prog();
        rst_n = 1'b0;
        rd_n = 0; wr_n = 0; dsp_n = 0; late_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (halted) break;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        put(0, 64);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "acc in reset", int'(acc_out), 0);
        chk("R1", "zero in reset", int'(zero_flag), 0);
        chk("R1", "neg in reset", int'(neg_flag), 0);
        chk("R1", "halted in reset", int'(halted), 0);
        chk("R1", "illegal in reset", int'(illegal), 0);
        chk("R1", "req in reset", int'(mem_req), 0);
        run_prog();
        chk("R1", "first read address", rd_log[0], 0);
        chk("R10", "halted after HLT", int'(halted), 1);
        chk("R10", "reads for lone HLT", rd_n, 1);
        chk("R10", "strobes after halt", late_req, 0);
        chk("R11", "illegal after HLT", int'(illegal), 0);
    endtask

    task automatic t_fetch_order();
        clear_mem();
        put(0, 8); put(1, 91); put(2, 0); put(3, 50); put(4, 64); put(50, 9);
        run_prog();
        chk("R2", "read count", rd_n, 6);
        chk("R2", "read 0", rd_log[0], 0);
        chk("R2", "read 1", rd_log[1], 1);
        chk("R2", "read 2", rd_log[2], 2);
        chk("R2", "read 3", rd_log[3], 3);
        chk("R2", "read 4 data", rd_log[4], 50);
        chk("R2", "read 5", rd_log[5], 4);
        chk("R7", "acc after LDA", int'(acc_out), 9);
        chk("R7", "zero kept from CLA", int'(zero_flag), 1);
    endtask

    task automatic t_inc_flags();
        clear_mem();
        put(0, 91); put(1, 0); put(2, 50); put(3, 10); put(4, 64); put(50, 255);
        run_prog();
        chk("R6", "INC wrap acc", int'(acc_out), 0);
        chk("R6", "INC wrap zero", int'(zero_flag), 1);
        chk("R6", "INC wrap neg", int'(neg_flag), 0);
        put(50, 127);
        run_prog();
        chk("R6", "INC 127 acc", int'(acc_out), 128);
        chk("R6", "INC 127 zero", int'(zero_flag), 0);
        chk("R6", "INC 127 neg", int'(neg_flag), 1);
    endtask

    task automatic t_lda_cla();
        clear_mem();
        put(0, 91); put(1, 0); put(2, 50); put(3, 64); put(50, 200);
        run_prog();
        chk("R7", "LDA negative value", int'(acc_out), 200);
        chk("R7", "LDA leaves neg clear", int'(neg_flag), 0);
        put(3, 8); put(4, 64);
        run_prog();
        chk("R5", "CLA acc", int'(acc_out), 0);
        chk("R5", "CLA zero", int'(zero_flag), 1);
        chk("R5", "CLA neg", int'(neg_flag), 0);
    endtask

    task automatic t_add_sub();
        clear_mem();
        put(0, 91); put(1, 0); put(2, 50);
        put(3, 61); put(4, 0); put(5, 51);
        put(6, 64);
        put(50, 10); put(51, 20);
        run_prog();
        chk("R6", "SUB negative acc", int'(acc_out), 246);
        chk("R6", "SUB negative neg", int'(neg_flag), 1);
        chk("R6", "SUB negative zero", int'(zero_flag), 0);
        put(6, 99); put(7, 0); put(8, 51);
        put(9, 61); put(10, 0); put(11, 50);
        put(12, 64);
        run_prog();
        chk("R6", "ADD then SUB acc", int'(acc_out), 0);
        chk("R6", "ADD then SUB zero", int'(zero_flag), 1);
        chk("R6", "ADD then SUB neg", int'(neg_flag), 0);
    endtask

    task automatic t_jumps();
        clear_mem();
        put(0, 8);
        put(1, 17); put(2, 0); put(3, 10);
        put(4, 1);  put(5, 0); put(6, 60);
        put(7, 64);
        put(10, 19); put(11, 0); put(12, 20);
        put(13, 1);  put(14, 0); put(15, 61);
        put(16, 15); put(17, 0); put(18, 30);
        put(19, 64);
        put(30, 1); put(31, 0); put(32, 62);
        put(33, 64);
        put(60, 11); put(61, 22); put(62, 33);
        run_prog();
        chk("R8", "display count", dsp_n, 2);
        chk("R8", "JZ taken, JN not taken", dsp_log[0], 22);
        chk("R8", "JMP target", dsp_log[1], 33);
        chk("R9", "display after jumps zero kept", int'(zero_flag), 1);
    endtask

    task automatic t_addr_store();
        clear_mem();
        put(0, 91); put(1, 12); put(2, 34);
        put(3, 1);  put(4, 5);  put(5, 7);
        put(6, 39); put(7, 0);  put(8, 70);
        put(9, 64);
        put(1234, 77); put(507, 88);
        run_prog();
        chk("R3", "data read address", rd_log[3], 1234);
        chk("R3", "acc from 1234", int'(acc_out), 77);
        chk("R9", "display from 507", dsp_log[0], 88);
        chk("R9", "display count", dsp_n, 1);
        chk("R4", "write count", wr_n, 1);
        chk("R4", "write address", wr_addr_log[0], 70);
        chk("R4", "write data", wr_data_log[0], 77);
        chk("R4", "memory after store", int'(mem[70]), 77);
    endtask

    task automatic t_illegal();
        clear_mem();
        put(0, 3); put(1, 91); put(2, 0);
        run_prog();
        chk("R11", "illegal raised", int'(illegal), 1);
        chk("R11", "halted raised", int'(halted), 1);
        chk("R11", "no operand read", rd_n, 1);
        chk("R11", "no strobe after", late_req, 0);
    endtask

    task automatic t_division();
        clear_mem();
        put(0, 8);
        put(1, 39);  put(2, 0);  put(3, 44);
        put(4, 91);  put(5, 0);  put(6, 42);
        put(7, 61);  put(8, 0);  put(9, 43);
        put(10, 19); put(11, 0); put(12, 29);
        put(13, 39); put(14, 0); put(15, 46);
        put(16, 91); put(17, 0); put(18, 44);
        put(19, 10);
        put(20, 39); put(21, 0); put(22, 44);
        put(23, 91); put(24, 0); put(25, 46);
        put(26, 15); put(27, 0); put(28, 7);
        put(29, 99); put(30, 0); put(31, 43);
        put(32, 39); put(33, 0); put(34, 45);
        put(35, 1);  put(36, 0); put(37, 44);
        put(38, 1);  put(39, 0); put(40, 45);
        put(41, 64);
        put(42, 25); put(43, 7);
        run_prog();
        chk("R12", "display count", dsp_n, 2);
        chk("R12", "quotient shown", dsp_log[0], 3);
        chk("R12", "remainder shown", dsp_log[1], 4);
        chk("R12", "quotient stored", int'(mem[44]), 3);
        chk("R12", "remainder stored", int'(mem[45]), 4);
        chk("R12", "halted", int'(halted), 1);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fetch_order();
        t_inc_flags();
        t_lda_cla();
        t_add_sub();
        t_jumps();
        t_addr_store();
        t_illegal();
        t_division();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule